// File: doc/BRIEF.md
# Link Rate and Lane Count Fallback Controller

This block picks the per-lane rate and the number of active lanes for a serial display link, given the payload bandwidth that the stream needs. It first finds the smallest lane count that still carries that bandwidth at the starting rate. It then moves to the lower rate if that lane count still has room there. With that choice it drives the transmitter configuration fields and the two sink configuration bytes, clears the training status buffer, and launches an external training sequencer. It then waits for the sequencer's verdict.

When training fails, the controller steps to the next lower rate. It computes the lane count again from the maximum and repeats the attempt. Once no lower rate is left, it gives up. In every outcome it ends by selecting the "pattern off" training code. It raises a one-cycle completion strobe and holds a flag that says whether any attempt succeeded. The two rates are 270000 and 162000 kB/s per lane. A sink that supports only the low rate starts the walk at the second entry.

Top module: `link_fallback_ctrl`

## Requirements
- R1: On `start`, the first attempt uses the high rate (270000 kB/s per lane) unless `low_rate_only` is 1, in which case it uses the low rate (162000).
- R2: For each attempt, the lane count starts at `max_lanes` (legal values 1, 2, 4). It halves while (lanes/2) × rate is greater than `data_rate`.
- R3: After the lanes are fixed at the high rate, the attempt moves to the low rate when 162000 × lanes is greater than `data_rate`.
- R4: `clk_word` equals 32'h0004_0000 at the high rate and 0 at the low rate. Its write mask `clk_mask` is 32'h000C_0000.
- R5: `ctrl_word` holds ((1<<lanes)−1) in bits 20:16 and the framing enable in bit 14. Its mask `ctrl_mask` is 32'h001F_4000.
- R6: `sink_bw` is 8'h0A at the high rate and 8'h06 at the low rate. `sink_lanes` is the lane count, with bit 7 set when `enh_frame` was 1 at start.
- R7: Each attempt pulses `cfg_we` for one cycle. `stat_clr` follows in the next cycle, and `train_go` in the cycle after that.
- R8: When the sequencer answers with `train_ok`=0, the next attempt is made at the next lower rate. A failure at the low rate ends the run, so there are at most two attempts.
- R9: Every run ends with one cycle in which `done` and `pattern_we` are high and `pattern_sel` is 0. From that cycle on, `link_ok` is 1 exactly when an attempt was answered with `train_ok`=1.
- R10: After reset, `busy`, `done`, `link_ok`, `cfg_we`, `stat_clr`, `train_go` and `pattern_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (taken while idle) |
| max_lanes | input | LANE_W | Maximum lane count: 1, 2 or 4 |
| low_rate_only | input | 1 | Sink supports only the low rate |
| enh_frame | input | 1 | Enhanced framing enable |
| data_rate | input | DR_W | Required bandwidth in kB/s |
| train_done | input | 1 | Training sequencer finished an attempt |
| train_ok | input | 1 | Attempt result, valid with train_done |
| train_go | output | 1 | Launch one training attempt |
| stat_clr | output | 1 | Clear the training status buffer |
| cfg_we | output | 1 | Write strobe for config words and sink bytes |
| clk_word | output | 32 | Rate clock field value |
| clk_mask | output | 32 | Rate clock field mask |
| ctrl_word | output | 32 | Lane enable and framing value |
| ctrl_mask | output | 32 | Lane enable and framing mask |
| sink_bw | output | 8 | Sink rate code byte |
| sink_lanes | output | 8 | Sink lane count byte |
| pattern_we | output | 1 | Write strobe for training pattern |
| pattern_sel | output | 4 | Training pattern code (0 = off) |
| lanes | output | LANE_W | Lane count of the current attempt |
| hi_rate | output | 1 | Current attempt uses the high rate |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion strobe |
| link_ok | output | 1 | Last run trained successfully |

## Verification
The bench drives random data rates across the full range with every legal lane maximum and both sink rate limits. This shows whether the lane halving and the rate drop pick the same pair as an independent model. Random pass/fail answers from the stand-in sequencer separate a single-attempt success, a fallback to the low rate with the lanes recomputed, and exhaustion after two failures. Directed cases cover a zero data rate, which collapses the link to one lane at the low rate. They also cover a rate exactly equal to one lane's capacity, where the strict comparisons decide, and the largest data rate, which needs every lane at the high rate.

// File: rtl/lf_pkg.sv
package lf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PLAN, ST_PROG, ST_CLR, ST_GO, ST_WAIT, ST_NEXT, ST_END
  } lf_state_e;

  localparam logic [7:0] CODE_HI = 8'h0A;
  localparam logic [7:0] CODE_LO = 8'h06;
  localparam logic [31:0] CLK_FIELD_MASK  = 32'h000C_0000;
  localparam logic [31:0] CLK_FIELD_HI    = 32'h0004_0000;
  localparam logic [31:0] CTRL_FIELD_MASK = 32'h001F_4000;
  localparam int LANE_EN_LSB = 16;
  localparam int ENH_BIT     = 14;

  // Per-lane rate at a list index; zero ends the list.
  function automatic logic [31:0] rate_at(input logic [1:0] idx,
                                          input logic [31:0] hi,
                                          input logic [31:0] lo);
    case (idx)
      2'd0:    rate_at = hi;
      2'd1:    rate_at = lo;
      default: rate_at = 32'd0;
    endcase
  endfunction

  // Smallest lane count reached by halving from the maximum while half
  // the lanes would still exceed the required bandwidth.
  function automatic logic [7:0] fit_lanes(input logic [7:0] max_l,
                                           input logic [31:0] rate,
                                           input logic [31:0] need);
    logic [7:0] l;
    l = max_l;
    for (int i = 0; i < 8; i++) begin
      if ((32'(l >> 1) * rate) > need) l = l >> 1;
    end
    fit_lanes = l;
  endfunction

endpackage

// File: rtl/lf_planner.sv
module lf_planner
  import lf_pkg::*;
#(
  parameter int LANE_W  = 3,
  parameter int DR_W    = 24,
  parameter logic [31:0] RATE_HI = 32'd270000,
  parameter logic [31:0] RATE_LO = 32'd162000
) (
  input  logic [1:0]        idx_in,
  input  logic [LANE_W-1:0] max_lanes,
  input  logic [DR_W-1:0]   need,
  output logic [LANE_W-1:0] lanes_out,
  output logic [1:0]        idx_out
);
  logic [31:0] need32, rate_now, rate_next;
  logic [7:0]  fitted;

  always_comb begin
    need32    = 32'(need);
    rate_now  = rate_at(idx_in, RATE_HI, RATE_LO);
    fitted    = fit_lanes(8'(max_lanes), rate_now, need32);
    rate_next = rate_at(idx_in + 2'd1, RATE_HI, RATE_LO);
    idx_out   = idx_in;
    // Only one lower entry can exist past the high rate.
    if (rate_next * 32'(fitted) > need32) idx_out = idx_in + 2'd1;
    lanes_out = LANE_W'(fitted);
  end
endmodule

// File: rtl/lf_encoder.sv
module lf_encoder
  import lf_pkg::*;
#(
  parameter int LANE_W = 3
) (
  input  logic [LANE_W-1:0] lanes,
  input  logic              hi_rate,
  input  logic              enh,
  output logic [31:0]       clk_word,
  output logic [31:0]       ctrl_word,
  output logic [7:0]        sink_bw,
  output logic [7:0]        sink_lanes
);
  logic [4:0] lane_en;

  always_comb begin
    lane_en    = 5'((32'd1 << lanes) - 32'd1);
    clk_word   = hi_rate ? CLK_FIELD_HI : 32'd0;
    ctrl_word  = 32'd0;
    ctrl_word[LANE_EN_LSB +: 5] = lane_en;
    ctrl_word[ENH_BIT]          = enh;
    sink_bw    = hi_rate ? CODE_HI : CODE_LO;
    sink_lanes = {enh, 7'(lanes)};
  end
endmodule

// File: rtl/link_fallback_ctrl.sv
module link_fallback_ctrl
  import lf_pkg::*;
#(
  parameter int LANE_W  = 3,
  parameter int DR_W    = 24,
  parameter logic [31:0] RATE_HI = 32'd270000,
  parameter logic [31:0] RATE_LO = 32'd162000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LANE_W-1:0] max_lanes,
  input  logic              low_rate_only,
  input  logic              enh_frame,
  input  logic [DR_W-1:0]   data_rate,
  input  logic              train_done,
  input  logic              train_ok,
  output logic              train_go,
  output logic              stat_clr,
  output logic              cfg_we,
  output logic [31:0]       clk_word,
  output logic [31:0]       clk_mask,
  output logic [31:0]       ctrl_word,
  output logic [31:0]       ctrl_mask,
  output logic [7:0]        sink_bw,
  output logic [7:0]        sink_lanes,
  output logic              pattern_we,
  output logic [3:0]        pattern_sel,
  output logic [LANE_W-1:0] lanes,
  output logic              hi_rate,
  output logic              busy,
  output logic              done,
  output logic              link_ok
);
  lf_state_e         st;
  logic [1:0]        idx_q;
  logic [LANE_W-1:0] lanes_q, max_q;
  logic [DR_W-1:0]   dr_q;
  logic              enh_q, ok_q;

  logic [LANE_W-1:0] plan_lanes;
  logic [1:0]        plan_idx;
  logic              attempt_pass, attempt_fail, list_end;

  lf_planner #(.LANE_W(LANE_W), .DR_W(DR_W), .RATE_HI(RATE_HI), .RATE_LO(RATE_LO))
    u_plan (.idx_in(idx_q), .max_lanes(max_q), .need(dr_q),
            .lanes_out(plan_lanes), .idx_out(plan_idx));

  lf_encoder #(.LANE_W(LANE_W))
    u_enc (.lanes(lanes_q), .hi_rate(hi_rate), .enh(enh_q),
           .clk_word(clk_word), .ctrl_word(ctrl_word),
           .sink_bw(sink_bw), .sink_lanes(sink_lanes));

  assign attempt_pass = (st == ST_WAIT) && train_done && train_ok;
  assign attempt_fail = (st == ST_WAIT) && train_done && !train_ok;
  assign list_end     = rate_at(idx_q + 2'd1, RATE_HI, RATE_LO) == 32'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      idx_q   <= 2'd0;
      lanes_q <= '0;
      max_q   <= '0;
      dr_q    <= '0;
      enh_q   <= 1'b0;
      ok_q    <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          max_q <= max_lanes;
          dr_q  <= data_rate;
          enh_q <= enh_frame;
          idx_q <= low_rate_only ? 2'd1 : 2'd0;
          ok_q  <= 1'b0;
          st    <= ST_PLAN;
        end
        ST_PLAN: begin
          lanes_q <= plan_lanes;
          idx_q   <= plan_idx;
          st      <= ST_PROG;
        end
        ST_PROG: st <= ST_CLR;
        ST_CLR:  st <= ST_GO;
        ST_GO:   st <= ST_WAIT;
        ST_WAIT: begin
          if (attempt_pass) begin
            ok_q <= 1'b1;
            st   <= ST_END;
          end else if (attempt_fail) begin
            st <= ST_NEXT;
          end
        end
        ST_NEXT: begin
          if (list_end) st <= ST_END;
          else begin
            idx_q <= idx_q + 2'd1;
            st    <= ST_PLAN;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign hi_rate     = (idx_q == 2'd0);
  assign lanes       = lanes_q;
  assign cfg_we      = (st == ST_PROG);
  assign stat_clr    = (st == ST_CLR);
  assign train_go    = (st == ST_GO);
  assign pattern_we  = (st == ST_END);
  assign pattern_sel = 4'd0;
  assign done        = (st == ST_END);
  assign busy        = (st != ST_IDLE);
  assign link_ok     = ok_q;
  assign clk_mask    = CLK_FIELD_MASK;
  assign ctrl_mask   = CTRL_FIELD_MASK;

  // R7
  clr_after_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> stat_clr);
  // R7
  go_after_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr |=> train_go);
  // R2
  lane_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> (lanes_q == LANE_W'(1)) ||
      ((32'(lanes_q >> 1) * (hi_rate ? RATE_HI : RATE_LO)) <= 32'(dr_q)));
  // R3
  rate_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && hi_rate) |-> (RATE_LO * 32'(lanes_q)) <= 32'(dr_q));
  // R5
  lane_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> ($countones(ctrl_word[20:16]) == int'(lanes_q)));
  // R6
  sink_enh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> (sink_lanes[7] == enh_q));
  // R9
  pass_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    attempt_pass |=> (done && link_ok));
  // R8
  hi_fail_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (attempt_fail && hi_rate) |=> !done);
endmodule

// File: tb/link_fallback_ctrl_bench.sv
module link_fallback_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  max_lanes = 3'd4;
  logic        low_rate_only = 1'b0;
  logic        enh_frame = 1'b0;
  logic [23:0] data_rate = '0;
  logic        train_done = 1'b0;
  logic        train_ok = 1'b0;
  logic        train_go, stat_clr, cfg_we, pattern_we, hi_rate, busy, done, link_ok;
  logic [31:0] clk_word, clk_mask, ctrl_word, ctrl_mask;
  logic [7:0]  sink_bw, sink_lanes;
  logic [3:0]  pattern_sel;
  logic [2:0]  lanes;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  link_fallback_ctrl u_link_fallback_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .max_lanes(max_lanes),
    .low_rate_only(low_rate_only), .enh_frame(enh_frame), .data_rate(data_rate),
    .train_done(train_done), .train_ok(train_ok), .train_go(train_go),
    .stat_clr(stat_clr), .cfg_we(cfg_we), .clk_word(clk_word), .clk_mask(clk_mask),
    .ctrl_word(ctrl_word), .ctrl_mask(ctrl_mask), .sink_bw(sink_bw),
    .sink_lanes(sink_lanes), .pattern_we(pattern_we), .pattern_sel(pattern_sel),
    .lanes(lanes), .hi_rate(hi_rate), .busy(busy), .done(done), .link_ok(link_ok));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Independent model: the attempts a run should make.
  int e_n;
  int e_l[2];
  bit e_hi[2];
  bit e_ok;

  task automatic model(input int ml, input bit lo, input int dr, input bit [1:0] fail);
    int r;
    int rate;
    int l;
    r = lo ? 1 : 0;
    e_n = 0;
    e_ok = 0;
    while (r < 2 && !e_ok) begin
      rate = (r == 0) ? 270000 : 162000;
      l = ml;
      while (l > 1 && (l / 2) * rate > dr) l = l / 2;
      if (r == 0 && 162000 * l > dr) r = 1;
      e_l[e_n] = l;
      e_hi[e_n] = (r == 0);
      if (!fail[e_n]) e_ok = 1;
      e_n++;
      r++;
    end
  endtask

  task automatic run_case(input int ml, input bit lo, input bit enh, input int dr,
                          input bit [1:0] fail);
    int k = 0;
    int clrs = 0;
    int resp = 0;
    bit got_end = 0;
    model(ml, lo, dr, fail);
    @(negedge clk);
    max_lanes = 3'(ml);
    low_rate_only = lo;
    enh_frame = enh;
    data_rate = 24'(dr);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 0; cyc < 100 && !got_end; cyc++) begin
      if (train_done) train_done = 1'b0;
      if (cfg_we) begin
        if (k < e_n) begin
          // R1 R3 rate of the attempt
          check("R3 rate", 32'(hi_rate), 32'(e_hi[k]));
          // R2 lane count
          check("R2 lanes", 32'(lanes), 32'(e_l[k]));
          // R4 clock field
          check("R4 clk_word", clk_word, e_hi[k] ? 32'h0004_0000 : 32'd0);
          // R5 lane enable and framing
          check("R5 ctrl_word", ctrl_word,
                (((32'd1 << e_l[k]) - 1) << 16) | (32'(enh) << 14));
          // R6 sink bytes
          check("R6 sink bytes", {16'd0, sink_bw, sink_lanes},
                {16'd0, e_hi[k] ? 8'h0A : 8'h06, enh, 7'(e_l[k])});
        end
        k++;
      end
      if (stat_clr) clrs++;
      if (train_go) begin
        // R7 one status clear per attempt, before the launch
        check("R7 clear before go", 32'(clrs), 32'(k));
        resp = 3;
      end else if (resp > 0) begin
        resp--;
        if (resp == 0) begin
          train_done = 1'b1;
          train_ok = !fail[k-1];
        end
      end
      if (done) begin
        got_end = 1;
        // R9 closing pattern
        check("R9 pattern off", {30'd0, pattern_we, 1'b0} | 32'(pattern_sel), 32'd2);
      end
      @(negedge clk);
    end
    check("R9 run ended", 32'(got_end), 32'd1);
    // R8 number of attempts
    check("R8 attempts", 32'(k), 32'(e_n));
    // R9 result flag
    check("R9 link_ok", 32'(link_ok), 32'(e_ok));
    check("R9 idle after", 32'(busy), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int ml_pick;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 reset", {25'd0, busy, done, link_ok, cfg_we, stat_clr, train_go, pattern_we},
          32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 idle", {30'd0, busy, done}, 32'd0);
    // Directed corners
    run_case(4, 0, 0, 0, 2'b00);          // collapses to one lane, low rate
    run_case(4, 0, 1, 1080000, 2'b00);    // all lanes at high rate
    run_case(4, 0, 1, 270000, 2'b00);     // equality boundary
    run_case(4, 0, 0, 1080000, 2'b11);    // both attempts fail
    run_case(2, 1, 1, 300000, 2'b01);     // R1 low-only, single failure ends
    run_case(4, 0, 0, 1000000, 2'b01);    // R8 fallback recomputes lanes
    for (int t = 0; t < 60; t++) begin
      ml_pick = $urandom_range(0, 2);
      run_case(1 << ml_pick, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               $urandom_range(0, 1200000), 2'($urandom_range(0, 3)));
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule